// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block gathers the interrupt events of a small microcontroller into eleven pending flags and reports the most urgent one to the CPU as a vector number with a request line. Two of the eleven sources are produced inside the block. A 16-bit free-running counter advances on a 1 MHz enable strobe, and the block watches two of its bits: bit 6, which rises about every 128 microseconds, and bit 9, which rises about every 1.024 milliseconds. A low-to-high change on either bit is an event. The remaining nine sources arrive as single-cycle pulses. There are five endpoint events, one hub event, one analog-port group event, one GPIO group event and one serial-master event.

Each source has its own enable bit. An event on an enabled source sets its pending flag. The flag stays set until the CPU acknowledges that vector or software clears it through a per-source clear strobe. Among the enabled pending sources, the one with the lowest index wins. Its index is presented on a registered 4-bit vector. A global enable gates the request line without touching the flags.

Source indices, which are also the vector numbers and the priority order, are: 0 for the bit-6 timer tap, 1 for the bit-9 timer tap, 2 to 6 for endpoints 0 to 4, 7 for the hub, 8 for the analog port, 9 for GPIO and 10 for the serial master.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the timer, all pending flags, `irq_req` and `irq_vec` become 0.
- R2: `tmr_val` rises by one (wrapping from 0xFFFF to 0) on each edge where `tick_1us` is high, and holds on every other edge.
- R3: When `tmr_val` bit 6 has just changed from 0 to 1, pending bit 0 is set on the next edge, provided `src_en[0]` is 1. A 1-to-0 change of that bit sets nothing.
- R4: When `tmr_val` bit 9 has just changed from 0 to 1, pending bit 1 is set on the next edge, provided `src_en[1]` is 1.
- R5: A high level on an external event input at an edge sets the matching pending bit: `ep_evt[k]` sets bit k+2, `hub_evt` bit 7, `anlg_evt` bit 8, `gpio_evt` bit 9 and `ser_evt` bit 10.
- R6: An event whose source has `src_en` bit 0 is dropped, and its pending bit stays 0.
- R7: A pending bit stays set until a `sw_clr` bit or an acknowledge removes it. If a new event on the same source comes in the same cycle as the clear, the bit stays set.
- R8: `irq_vec` gives the lowest index whose pending bit and enable bit are both 1, or 0 when there is none. It is updated on the same edge as the pending flags.
- R9: `irq_req` is 1 exactly when `glb_en` was 1 at the last edge and some enabled source is pending. `glb_en` low never clears a pending bit.
- R10: `irq_ack` high at an edge while `irq_req` is 1 clears only the pending bit numbered by `irq_vec`. While `irq_req` is 0, `irq_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1us | input | 1 | 1 MHz enable strobe for the timer |
| ep_evt | input | 5 | Endpoint event pulses (sources 2..6) |
| hub_evt | input | 1 | Hub event pulse (source 7) |
| anlg_evt | input | 1 | Analog-port group event pulse (source 8) |
| gpio_evt | input | 1 | GPIO group event pulse (source 9) |
| ser_evt | input | 1 | Serial-master event pulse (source 10) |
| src_en | input | 11 | Per-source enable mask |
| glb_en | input | 1 | Global request enable |
| sw_clr | input | 11 | Per-source software clear strobes |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 4 | Winning source number |
| pend_out | output | 11 | Pending flags |
| tmr_val | output | 16 | Free-running timer value |

## Verification
The delicate case is a new event landing on the same source, in the same cycle, as its removal. The removal can come from an acknowledge of the presented vector or from a software clear strobe. The bench provokes both: it pulses an endpoint input together with `sw_clr` for that source, and it pulses the presented source's input together with `irq_ack`. It expects the flag to remain set and the vector to stay on that source, and a later lone acknowledge to clear it. A behavioural model of counter, flags and selection is stepped every clock and compared with all outputs, so timer taps that fire during acknowledges are judged as well.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Fixed source positions (they set both vector number and priority)
  localparam int unsigned SRC_TMR_FAST = 0;
  localparam int unsigned SRC_TMR_SLOW = 1;
  localparam int unsigned SRC_EP_FIRST = 2;

  // Number of timer-derived sources and of the single group sources
  localparam int unsigned TMR_SRC_CNT  = 2;
  localparam int unsigned GRP_SRC_CNT  = 4;

  // Single group events, packed high to low in source order
  typedef struct packed {
    logic ser;
    logic gpio;
    logic anlg;
    logic hub;
  } grp_evt_t;

endpackage

// File: rtl/irq_tap_timer.sv
module irq_tap_timer #(
  parameter int CNT_W    = 16,
  parameter int FAST_TAP = 6,
  parameter int SLOW_TAP = 9,
  localparam int NTAP    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NTAP-1:0]  rise_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // One rising-edge detector per watched counter bit
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int POS = (g == 0) ? FAST_TAP : SLOW_TAP;
    logic seen_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q <= 1'b0;
      end else begin
        seen_q <= cnt_q[POS];
      end
    end

    assign rise_o[g] = cnt_q[POS] & ~seen_q;
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_nxt_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    logic flag_d;

    // A fresh enabled event outranks a clear in the same cycle
    assign flag_d = (flag_q & ~clr_i[i]) | (set_i[i] & en_i[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
      end else begin
        flag_q <= flag_d;
      end
    end

    assign pend_o[i]     = flag_q;
    assign pend_nxt_o[i] = flag_d;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_EP   = 5,
  parameter int TMR_W    = 16,
  parameter int FAST_TAP = 6,
  parameter int SLOW_TAP = 9,
  localparam int NUM_SRC = NUM_EP + 6,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1us,
  input  logic [NUM_EP-1:0]  ep_evt,
  input  logic               hub_evt,
  input  logic               anlg_evt,
  input  logic               gpio_evt,
  input  logic               ser_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] sw_clr,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [NUM_SRC-1:0] pend_out,
  output logic [TMR_W-1:0]   tmr_val
);

  import irq_pkg::*;

  localparam int GRP_BASE = SRC_EP_FIRST + NUM_EP;

  logic [TMR_SRC_CNT-1:0] tap_rise;
  logic [NUM_SRC-1:0]     evt_all;
  logic [NUM_SRC-1:0]     ack_hot;
  logic [NUM_SRC-1:0]     clr_all;
  logic [NUM_SRC-1:0]     pend_q;
  logic [NUM_SRC-1:0]     pend_nxt;
  logic                   win_any;
  logic [VEC_W-1:0]       win_idx;
  logic                   req_q;
  logic [VEC_W-1:0]       vec_q;
  grp_evt_t               grp;

  irq_tap_timer #(
    .CNT_W    (TMR_W),
    .FAST_TAP (FAST_TAP),
    .SLOW_TAP (SLOW_TAP)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_1us),
    .cnt_o  (tmr_val),
    .rise_o (tap_rise)
  );

  assign grp = '{ser: ser_evt, gpio: gpio_evt, anlg: anlg_evt, hub: hub_evt};

  always_comb begin
    evt_all = '0;
    evt_all[SRC_TMR_FAST] = tap_rise[0];
    evt_all[SRC_TMR_SLOW] = tap_rise[1];
    evt_all[SRC_EP_FIRST +: NUM_EP] = ep_evt;
    evt_all[GRP_BASE +: GRP_SRC_CNT] = grp;
  end

  // Acknowledge only counts while a request is shown
  always_comb begin
    ack_hot = '0;
    if (irq_ack && req_q) begin
      ack_hot = {{(NUM_SRC - 1){1'b0}}, 1'b1} << vec_q;
    end
  end

  assign clr_all = sw_clr | ack_hot;

  irq_pend_bank #(
    .N (NUM_SRC)
  ) u_pend (
    .clk        (clk),
    .rst        (rst),
    .set_i      (evt_all),
    .en_i       (src_en),
    .clr_i      (clr_all),
    .pend_o     (pend_q),
    .pend_nxt_o (pend_nxt)
  );

  // Select from next-state flags so outputs line up with pend_out
  irq_prio_pick #(
    .N     (NUM_SRC),
    .IDX_W (VEC_W)
  ) u_pick (
    .cand_i (pend_nxt & src_en),
    .any_o  (win_any),
    .idx_o  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= glb_en & win_any;
      vec_q <= win_idx;
    end
  end

  assign irq_req  = req_q;
  assign irq_vec  = vec_q;
  assign pend_out = pend_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NSRC = 11,
  parameter int VW   = 4,
  parameter int TW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_1us,
  input logic [NSRC-1:0] src_en,
  input logic            glb_en,
  input logic [NSRC-1:0] sw_clr,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic [NSRC-1:0] pend_out,
  input logic [TW-1:0]   tmr_val
);

  logic [NSRC-1:0] ack_mask;

  always_comb begin
    ack_mask = '0;
    if (irq_ack && irq_req) begin
      ack_mask = {{(NSRC - 1){1'b0}}, 1'b1} << irq_vec;
    end
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick_1us)) |-> (tmr_val == TW'($past(tmr_val) + 1'b1))); // R2

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_1us)) |-> $stable(tmr_val)); // R2

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_out & ~$past(pend_out) & ~$past(src_en)) == '0)); // R6

  AST_NO_LOST_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_out) & ~pend_out & ~$past(sw_clr | ack_mask)) == '0)); // R7

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) < NSRC)); // R8

  AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> pend_out[irq_vec]); // R8

  AST_GLB_GATES_REQ: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en) |-> !irq_req); // R9

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NSRC (NUM_SRC),
  .VW   (VEC_W),
  .TW   (TMR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1us (tick_1us),
  .src_en   (src_en),
  .glb_en   (glb_en),
  .sw_clr   (sw_clr),
  .irq_ack  (irq_ack),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .pend_out (pend_out),
  .tmr_val  (tmr_val)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_1us;
  logic [4:0]  ep_evt;
  logic        hub_evt, anlg_evt, gpio_evt, ser_evt;
  logic [10:0] src_en;
  logic        glb_en;
  logic [10:0] sw_clr;
  logic        irq_ack;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [10:0] pend_out;
  logic [15:0] tmr_val;

  int checks = 0;
  int errors = 0;

  // reference model state
  int       m_tmr = 0;
  bit       m_p6 = 0, m_p9 = 0;
  bit [10:0] m_pend = '0;
  bit       m_req = 0;
  int       m_vec = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk (clk), .rst (rst), .tick_1us (tick_1us), .ep_evt (ep_evt),
    .hub_evt (hub_evt), .anlg_evt (anlg_evt), .gpio_evt (gpio_evt),
    .ser_evt (ser_evt), .src_en (src_en), .glb_en (glb_en),
    .sw_clr (sw_clr), .irq_ack (irq_ack), .irq_req (irq_req),
    .irq_vec (irq_vec), .pend_out (pend_out), .tmr_val (tmr_val)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit [10:0] ev;
    bit [10:0] clr;
    if (rst) begin
      m_tmr = 0; m_p6 = 0; m_p9 = 0; m_pend = '0; m_req = 0; m_vec = 0;
    end else begin
      ev = '0;
      ev[0] = ((m_tmr >> 6) & 1) == 1 && !m_p6;
      ev[1] = ((m_tmr >> 9) & 1) == 1 && !m_p9;
      m_p6 = ((m_tmr >> 6) & 1) == 1;
      m_p9 = ((m_tmr >> 9) & 1) == 1;
      if (tick_1us) m_tmr = (m_tmr + 1) % 65536;
      for (int k = 0; k < 5; k++) ev[k+2] = ep_evt[k];
      ev[7] = hub_evt; ev[8] = anlg_evt; ev[9] = gpio_evt; ev[10] = ser_evt;
      clr = sw_clr;
      if (irq_ack && m_req) clr[m_vec] = 1'b1;
      m_pend = (m_pend & ~clr) | (ev & src_en);
      m_req = 0; m_vec = 0;
      for (int i = 10; i >= 0; i--) begin
        if (m_pend[i] && src_en[i]) begin
          m_vec = i;
          m_req = glb_en;
        end
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2;
    chk("R2 timer model", int'(tmr_val), m_tmr);
    chk("R7 pending model", int'(pend_out), int'(m_pend));
    chk("R9 request model", int'(irq_req), int'(m_req));
    chk("R8 vector model", int'(irq_vec), m_vec);
  endtask

  task automatic set_evt(int src, logic v);
    if (src >= 2 && src <= 6) ep_evt[src-2] = v;
    else if (src == 7) hub_evt = v;
    else if (src == 8) anlg_evt = v;
    else if (src == 9) gpio_evt = v;
    else if (src == 10) ser_evt = v;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; tick_1us = 1'b1; ep_evt = '0; hub_evt = 0; anlg_evt = 0;
    gpio_evt = 0; ser_evt = 0; src_en = '1; glb_en = 1'b1; sw_clr = '0; irq_ack = 0;
    repeat (3) cyc();
    chk("R1 timer reset", int'(tmr_val), 0);
    chk("R1 pending reset", int'(pend_out), 0);
    chk("R1 request reset", int'(irq_req), 0);
    chk("R1 vector reset", int'(irq_vec), 0);
    rst = 1'b0; tick_1us = 1'b0;
    cyc();

    // R5 / R10: each external source alone, then acknowledged
    for (int s = 2; s <= 10; s++) begin
      set_evt(s, 1'b1); cyc(); set_evt(s, 1'b0);
      chk("R5 source latched", int'(pend_out[s]), 1);
      chk("R8 single vector", int'(irq_vec), s);
      ack_once();
      chk("R10 ack clears", int'(pend_out[s]), 0);
    end

    // R6: masked source dropped
    src_en[7] = 1'b0;
    set_evt(7, 1'b1); cyc(); set_evt(7, 1'b0);
    chk("R6 masked dropped", int'(pend_out[7]), 0);
    chk("R6 no request", int'(irq_req), 0);
    src_en[7] = 1'b1; cyc();
    chk("R6 stays dropped", int'(pend_out[7]), 0);

    // R8: several at once, lowest index first
    ep_evt = 5'b10100; gpio_evt = 1; ser_evt = 1; cyc();
    ep_evt = '0; gpio_evt = 0; ser_evt = 0;
    chk("R8 first winner", int'(irq_vec), 4);
    ack_once();
    chk("R8 second winner", int'(irq_vec), 6);
    src_en[6] = 1'b0; cyc();
    chk("R8 mask skips", int'(irq_vec), 9);
    chk("R8 masked flag kept", int'(pend_out[6]), 1);
    src_en[6] = 1'b1; cyc();
    chk("R8 unmask returns", int'(irq_vec), 6);
    ack_once(); ack_once(); ack_once();
    chk("R10 all acked", int'(irq_req), 0);
    chk("R10 all flags clear", int'(pend_out), 0);

    // R9 / R10: global gate and ignored ack
    set_evt(3, 1'b1); glb_en = 1'b0; cyc(); set_evt(3, 1'b0);
    chk("R9 gated request", int'(irq_req), 0);
    chk("R9 flag kept", int'(pend_out[3]), 1);
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    chk("R10 ack ignored without request", int'(pend_out[3]), 1);
    glb_en = 1'b1; cyc();
    chk("R9 request back", int'(irq_req), 1);
    chk("R9 vector back", int'(irq_vec), 3);

    // R7: software clear, and event colliding with clear / ack
    sw_clr[3] = 1'b1; cyc(); sw_clr = '0;
    chk("R7 sw clear", int'(pend_out[3]), 0);
    set_evt(8, 1'b1); sw_clr[8] = 1'b1; cyc(); set_evt(8, 1'b0); sw_clr = '0;
    chk("R7 event beats sw clear", int'(pend_out[8]), 1);
    set_evt(8, 1'b1); irq_ack = 1'b1; cyc(); set_evt(8, 1'b0); irq_ack = 1'b0;
    chk("R7 event beats ack", int'(pend_out[8]), 1);
    chk("R7 vector held", int'(irq_vec), 8);
    ack_once();
    chk("R7 lone ack clears", int'(pend_out[8]), 0);

    // R3 / R4: timer taps
    tick_1us = 1'b1;
    while (tmr_val != 16'd64) cyc();
    chk("R3 not yet", int'(pend_out[0]), 0);
    cyc();
    chk("R3 bit6 rise", int'(pend_out[0]), 1);
    ack_once();
    while (tmr_val != 16'd512) cyc();
    chk("R4 not yet", int'(pend_out[1]), 0);
    cyc();
    chk("R4 bit9 rise", int'(pend_out[1]), 1);
    while (tmr_val != 16'd600) cyc();
    sw_clr = '1; cyc(); sw_clr = '0;
    while (tmr_val != 16'd642) cyc();
    chk("R3 fall ignored", int'(pend_out[0]), 0);

    // R2: sparse strobe and wrap
    begin
      int start;
      start = int'(tmr_val);
      for (int i = 0; i < 30; i++) begin
        tick_1us = (i % 3 == 0);
        cyc();
      end
      chk("R2 sparse count", int'(tmr_val), start + 10);
    end
    tick_1us = 1'b1;
    while (tmr_val != 16'hFFFF) cyc();
    cyc();
    chk("R2 wrap", int'(tmr_val), 0);

    finish_run();
  end

endmodule